// File: doc/BRIEF.md
# Four-Way Set-Associative Lookup Cache

This block is a read-only lookup cache with four ways of 256 sets each. A 32-bit request address is cut into a tag, a set index and a word offset. The tags held by all four ways at the selected set are compared in parallel. The registered response reports a hit together with the stored 32-bit word, or a miss.

On a miss the block does not fetch anything. Instead it hands back a sixteen-byte aligned address window around the missed address, and an outside agent is expected to load that window.

Filling is also done from outside. A write-enable input writes a tag, a data word and a valid flag into one chosen way. The set index for that write comes from a free-running counter that the block exposes, so the filling agent times its write to the cycle in which the counter shows the set it wants.

Top module: `assoc_lookup_cache`

## Requirements
- R1: The request address is split as tag = bits [31:10], set = bits [9:2] and offset = bits [1:0]. The offset bits have no effect on hit, miss or returned data.
- R2: A rising edge with `fill_we`=1 writes `fill_tag` and `fill_data` into way `fill_way` at set `fill_index`, and marks that entry valid. Entries of the other three ways are unchanged.
- R3: `fill_index` is 0 during reset. After reset it increases by one on every rising edge and wraps from 255 to 0.
- R4: A request sampled with `req_valid`=1 and `fill_we`=0 yields, in the next cycle only, exactly one of `hit` and `miss` high. Both are low in every cycle that follows no such request.
- R5: A hit is reported when any valid way at the request set holds the request tag. `rd_data` then carries that way's stored word.
- R6: When several ways match, the word of the lowest-numbered matching way is returned.
- R7: Reset clears every valid flag. An entry that has never been filled since reset never hits, whatever the tag.
- R8: On a miss, `win_valid` pulses with `miss`, `win_lo` = request address with bits [3:0] cleared, and `win_hi` = `win_lo` + 15. Both bounds hold their value until the next miss.
- R9: A request sampled while `fill_we`=1 is not looked up: `hit`, `miss` and `win_valid` stay low in the next cycle. The fill in that cycle still takes place.
- R10: `rd_data` is 0 after reset and after a miss. It changes only when a lookup is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Lookup address |
| fill_we | input | 1 | Fill write enable (1 = write, 0 = read) |
| fill_way | input | 2 | Way written by a fill |
| fill_tag | input | 22 | Tag stored by a fill |
| fill_data | input | 32 | Data word stored by a fill |
| fill_index | output | 8 | Free-running set index used by fills |
| hit | output | 1 | Registered hit pulse |
| miss | output | 1 | Registered miss pulse |
| rd_data | output | 32 | Word returned on a hit |
| win_valid | output | 1 | Miss window valid pulse |
| win_lo | output | 32 | Lower bound of the miss window |
| win_hi | output | 32 | Upper bound of the miss window |

## Verification
A fill and a lookup can be presented in the same cycle, and the block then gives the write precedence. The bench provokes this by raising `req_valid` in the very cycle it performs a fill whose counter-selected set and tag equal the request. It expects no hit, no miss and no window in the following cycle. A second, plain lookup of the same address must then return the newly written word.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int ADDR_W   = 32;
    localparam int TAG_W    = 22;
    localparam int SET_W    = 8;
    localparam int OFS_W    = 2;
    localparam int DATA_W   = 32;
    localparam int NUM_WAYS = 4;
    localparam int WIN_LSB  = 4;
    localparam int WAY_W    = $clog2(NUM_WAYS);

    typedef struct packed {
        logic              hit;
        logic              miss;
        logic [DATA_W-1:0] rdata;
        logic              win_v;
        logic [ADDR_W-1:0] win_lo;
        logic [ADDR_W-1:0] win_hi;
    } resp_t;
endpackage

// File: rtl/lc_fill_counter.sv
module lc_fill_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '1) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/lc_way_store.sv
module lc_way_store #(
    parameter int TAG_W  = 22,
    parameter int SET_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              match,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [DATA_W-1:0] dat_mem [SETS];
    logic [SETS-1:0]   vld_d, vld_q;

    always_comb begin
        vld_d = vld_q;
        if (wr_en) vld_d[wr_set] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_set] <= wr_tag;
            dat_mem[wr_set] <= wr_data;
        end
    end

    // Tag comparator for this way
    assign match   = vld_q[rd_set] && (tag_mem[rd_set] == rd_tag);
    assign rd_data = dat_mem[rd_set];

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_set)]); // R2
    AST_FILL_THEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_set == $past(wr_set) && rd_tag == $past(wr_tag)) -> match)); // R2
endmodule

// File: rtl/lc_hit_pick.sv
module lc_hit_pick #(
    parameter int NUM_WAYS = 4,
    parameter int DATA_W   = 32
) (
    input  logic [NUM_WAYS-1:0]             match,
    input  logic [NUM_WAYS-1:0][DATA_W-1:0] way_data,
    output logic                            any_hit,
    output logic [DATA_W-1:0]               sel_data
);
    always_comb begin
        any_hit  = 1'b0;
        sel_data = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (match[i] && !any_hit) begin
                any_hit  = 1'b1;
                sel_data = way_data[i];
            end
        end
    end
endmodule

// File: rtl/lc_miss_window.sv
module lc_miss_window #(
    parameter int ADDR_W  = 32,
    parameter int WIN_LSB = 4
) (
    input  logic [ADDR_W-WIN_LSB-1:0] blk,
    output logic [ADDR_W-1:0]         lo,
    output logic [ADDR_W-1:0]         hi
);
    localparam logic [ADDR_W-1:0] SPAN = {{(ADDR_W-WIN_LSB){1'b0}}, {WIN_LSB{1'b1}}};

    assign lo = {blk, {WIN_LSB{1'b0}}};
    assign hi = lo + SPAN;
endmodule

// File: rtl/assoc_lookup_cache.sv
module assoc_lookup_cache
    import lc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  fill_we,
    input  logic [WAY_W-1:0]      fill_way,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic [DATA_W-1:0]     fill_data,
    output logic [SET_W-1:0]      fill_index,
    output logic                  hit,
    output logic                  miss,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  win_valid,
    output logic [ADDR_W-1:0]     win_lo,
    output logic [ADDR_W-1:0]     win_hi
);
    logic [TAG_W-1:0]                   req_tag;
    logic [SET_W-1:0]                   req_set;
    logic [NUM_WAYS-1:0]                way_match;
    logic [NUM_WAYS-1:0][DATA_W-1:0]    way_rdata;
    logic                               any_hit;
    logic [DATA_W-1:0]                  sel_data;
    logic [ADDR_W-1:0]                  nb_lo, nb_hi;
    logic                               lookup;
    resp_t                              resp_d, resp_q;

    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign req_set = req_addr[OFS_W +: SET_W];
    assign lookup  = req_valid && !fill_we;

    lc_fill_counter #(.CNT_W(SET_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (fill_index)
    );

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        lc_way_store #(.TAG_W(TAG_W), .SET_W(SET_W), .DATA_W(DATA_W)) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (fill_we && (fill_way == WAY_W'(g))),
            .wr_set  (fill_index),
            .wr_tag  (fill_tag),
            .wr_data (fill_data),
            .rd_set  (req_set),
            .rd_tag  (req_tag),
            .match   (way_match[g]),
            .rd_data (way_rdata[g])
        );
    end

    lc_hit_pick #(.NUM_WAYS(NUM_WAYS), .DATA_W(DATA_W)) u_pick (
        .match    (way_match),
        .way_data (way_rdata),
        .any_hit  (any_hit),
        .sel_data (sel_data)
    );

    lc_miss_window #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_win (
        .blk (req_addr[ADDR_W-1:WIN_LSB]),
        .lo  (nb_lo),
        .hi  (nb_hi)
    );

    always_comb begin
        resp_d       = resp_q;
        resp_d.hit   = 1'b0;
        resp_d.miss  = 1'b0;
        resp_d.win_v = 1'b0;
        if (lookup) begin
            resp_d.hit   = any_hit;
            resp_d.miss  = !any_hit;
            resp_d.rdata = any_hit ? sel_data : '0;
            if (!any_hit) begin
                resp_d.win_v  = 1'b1;
                resp_d.win_lo = nb_lo;
                resp_d.win_hi = nb_hi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign hit       = resp_q.hit;
    assign miss      = resp_q.miss;
    assign rd_data   = resp_q.rdata;
    assign win_valid = resp_q.win_v;
    assign win_lo    = resp_q.win_lo;
    assign win_hi    = resp_q.win_hi;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fill_we) |=> (hit != miss)); // R4
    AST_QUIET_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !fill_we) |=> !(hit || miss || win_valid)); // R9
    AST_WIN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_lo[3:0] == 4'h0 && win_hi == win_lo + 32'd15)); // R8
    AST_WIN_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fill_we) |=> (miss -> (win_lo == ($past(req_addr) & ~32'hF)))); // R8
    AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (rd_data == '0)); // R10
    AST_DATA_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !fill_we) |=> $stable(rd_data)); // R10
endmodule

// File: tb/assoc_lookup_cache_tb.sv
`timescale 1ns/1ps
module assoc_lookup_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        fill_we = 1'b0;
    logic [1:0]  fill_way = '0;
    logic [21:0] fill_tag = '0;
    logic [31:0] fill_data = '0;
    logic [7:0]  fill_index;
    logic        hit, miss, win_valid;
    logic [31:0] rd_data, win_lo, win_hi;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    assoc_lookup_cache u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .fill_we(fill_we), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_data(fill_data), .fill_index(fill_index), .hit(hit), .miss(miss),
        .rd_data(rd_data), .win_valid(win_valid), .win_lo(win_lo), .win_hi(win_hi)
    );

    typedef struct packed {
        logic [21:0] tag;
        logic [7:0]  set;
        logic [1:0]  ofs;
        logic        exp_hit;
        logic [31:0] exp_data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{22'h12345,  8'h05, 2'd0, 1'b1, 32'hA000_0005},
        '{22'h12345,  8'h05, 2'd3, 1'b1, 32'hA000_0005},
        '{22'h00ABC,  8'h05, 2'd1, 1'b1, 32'hC200_0005},
        '{22'h3FFFFF, 8'h80, 2'd2, 1'b1, 32'hB100_0080},
        '{22'h00000,  8'hFF, 2'd0, 1'b1, 32'hD300_00FF},
        '{22'h11111,  8'h40, 2'd0, 1'b1, 32'h0A0A_0A0A},
        '{22'h12345,  8'h06, 2'd0, 1'b0, 32'h0},
        '{22'h12346,  8'h05, 2'd2, 1'b0, 32'h0},
        '{22'h00000,  8'h00, 2'd0, 1'b0, 32'h0},
        '{22'h00000,  8'hFE, 2'd3, 1'b0, 32'h0}
    };

    function automatic logic [31:0] mk(input logic [21:0] t, input logic [7:0] s, input logic [1:0] o);
        return {t, s, o};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [1:0] w, input logic [7:0] s, input logic [21:0] t, input logic [31:0] d);
        @(negedge clk);
        while (fill_index != s) @(negedge clk);
        fill_we = 1'b1; fill_way = w; fill_tag = t; fill_data = d;
        @(negedge clk);
        fill_we = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        logic [31:0] a, m;
        repeat (3) @(negedge clk);
        // Reset state: R3, R10
        check("R3 reset index", 32'(fill_index), 32'h0);
        check("R4 reset hit", 32'(hit), 32'h0);
        check("R4 reset miss", 32'(miss), 32'h0);
        check("R8 reset win_valid", 32'(win_valid), 32'h0);
        check("R10 reset rd_data", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 first step", 32'(fill_index), 32'h1);
        @(negedge clk);
        check("R3 second step", 32'(fill_index), 32'h2);

        // Fills (R2)
        do_fill(2'd0, 8'h05, 22'h12345,  32'hA000_0005);
        do_fill(2'd2, 8'h05, 22'h00ABC,  32'hC200_0005);
        do_fill(2'd1, 8'h80, 22'h3FFFFF, 32'hB100_0080);
        do_fill(2'd3, 8'hFF, 22'h00000,  32'hD300_00FF);
        do_fill(2'd2, 8'h40, 22'h11111,  32'h2C2C_2C2C);
        do_fill(2'd0, 8'h40, 22'h11111,  32'h0A0A_0A0A);

        // Vector table: R1 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            a = mk(VECS[i].tag, VECS[i].set, VECS[i].ofs);
            lookup(a);
            check("R5 vector hit", 32'(hit), 32'(VECS[i].exp_hit));
            check("R4 vector miss", 32'(miss), 32'(!VECS[i].exp_hit));
            check("R1/R6 vector data", rd_data, VECS[i].exp_data);
            if (!VECS[i].exp_hit) begin
                check("R8 win_valid", 32'(win_valid), 32'h1);
                check("R8 win_lo", win_lo, a & ~32'hF);
                check("R8 win_hi", win_hi, (a & ~32'hF) + 32'd15);
            end else begin
                check("R8 no window on hit", 32'(win_valid), 32'h0);
            end
        end

        // R4: one-cycle pulse, R10 data held
        lookup(mk(22'h12345, 8'h05, 2'd0));
        @(negedge clk);
        check("R4 pulse ends hit", 32'(hit), 32'h0);
        check("R4 pulse ends miss", 32'(miss), 32'h0);
        check("R10 data held idle", rd_data, 32'hA000_0005);

        // R8: bounds held across a hit
        m = mk(22'h2F0F0, 8'h9C, 2'd1);
        lookup(m);
        check("R8 miss seen", 32'(miss), 32'h1);
        lookup(mk(22'h00ABC, 8'h05, 2'd0));
        check("R8 hold valid low", 32'(win_valid), 32'h0);
        check("R8 hold lo", win_lo, m & ~32'hF);
        check("R8 hold hi", win_hi, (m & ~32'hF) + 32'd15);

        // R9: fill and request in the same cycle
        @(negedge clk);
        while (fill_index != 8'h33) @(negedge clk);
        fill_we = 1'b1; fill_way = 2'd1; fill_tag = 22'h2AAAA; fill_data = 32'h9999_0033;
        req_valid = 1'b1; req_addr = mk(22'h2AAAA, 8'h33, 2'd0);
        @(negedge clk);
        fill_we = 1'b0; req_valid = 1'b0;
        check("R9 no hit during fill", 32'(hit), 32'h0);
        check("R9 no miss during fill", 32'(miss), 32'h0);
        check("R9 no window during fill", 32'(win_valid), 32'h0);
        lookup(mk(22'h2AAAA, 8'h33, 2'd0));
        check("R9 fill took effect", rd_data, 32'h9999_0033);

        // R2: overwrite way 2 at set 5, way 0 untouched
        do_fill(2'd2, 8'h05, 22'h00ABD, 32'hC2C2_0005);
        lookup(mk(22'h00ABC, 8'h05, 2'd0));
        check("R2 old tag replaced", 32'(miss), 32'h1);
        lookup(mk(22'h00ABD, 8'h05, 2'd0));
        check("R2 new entry data", rd_data, 32'hC2C2_0005);
        lookup(mk(22'h12345, 8'h05, 2'd0));
        check("R2 other way kept", rd_data, 32'hA000_0005);

        // R3: wrap
        @(negedge clk);
        while (fill_index != 8'hFF) @(negedge clk);
        @(negedge clk);
        check("R3 wrap to zero", 32'(fill_index), 32'h0);

        // R7: reset clears valid flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup(mk(22'h12345, 8'h05, 2'd0));
        check("R7 miss after reset", 32'(miss), 32'h1);
        check("R7 no hit after reset", 32'(hit), 32'h0);
        lookup(mk(22'h00000, 8'hFF, 2'd0));
        check("R7 zero tag invalid", 32'(hit), 32'h0);

        done = 1'b1;
        summary();
    end
endmodule